// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command, address, bank, clock-enable and byte-mask pins of a four-bank, 16-bit single-data-rate SDRAM from reset until the memory is usable. While the clock-stable indication is low, it keeps the bus quiet. Once the clock is good, it counts out a long wait with NOP on the bus. It then closes every bank with one PRECHARGE and issues a programmable number (at least two) of AUTO REFRESH commands. Last, it writes the mode register with a fixed value.

Each command is followed by its own guard time of NOP cycles. After the guard that follows the mode load, the block raises `init_done` and holds it. A downstream access controller can then take the pins over. Every delay is a parameter counted in clock cycles. A synchronous reset starts the whole sequence again from the beginning.

Commands are coded on {cs_n, ras_n, cas_n, we_n} as follows:

| Command | cs_n ras_n cas_n we_n |
|---|---|
| NOP | 0111 |
| PRECHARGE | 0010 |
| AUTO REFRESH | 0001 |
| LOAD MODE | 0000 |

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, the pins carry NOP (0111) with `sd_addr`=0 and `sd_ba`=0, and `init_done` is low.
- R2: `sd_cke` is high and every `sd_dqm` bit is high in every cycle, reset included.
- R3: Only NOP is issued until `clk_stable` has been sampled high at WAIT_CYC+1 consecutive rising edges. A PRECHARGE (0010) appears in the cycle that follows that edge.
- R4: A low `clk_stable` at any edge before the precharge restarts the wait count from zero. After the precharge has been issued, `clk_stable` has no effect on the pins or on `init_done`.
- R5: The PRECHARGE drives `sd_addr` bit 10 high, all other address bits low, and `sd_ba`=0, so that all banks are selected.
- R6: Exactly T_RP NOP cycles follow the precharge, and then the first AUTO REFRESH (0001) is issued with address 0.
- R7: NUM_REF AUTO REFRESH commands are issued in total, with the count forced to at least 2. Each is followed by exactly T_RFC NOP cycles.
- R8: After the last refresh guard, one LOAD MODE (0000) is issued with `sd_addr`=MODE_VAL and `sd_ba`=0.
- R9: `init_done` rises after exactly T_MRD NOP cycles that follow the mode load. It then stays high with NOP on the bus until reset.
- R10: A reset at any point in the sequence, including after `init_done`, restarts the sequence from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every output changes just after its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_stable | input | 1 | High when power and clock are stable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus; bit 10 selects all banks on precharge |
| sd_ba | output | BA_W | Bank address |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | DQM_W | Byte masks |
| init_done | output | 1 | Sticky flag: initialization is complete |

## Verification
The assertions rely on the guard parameters being at least one cycle. The precharge, refresh and done checks rely on this because they require a NOP in the cycle before. They also assume that `rst` and `clk_stable` change only between clock edges. The stimulus changes both on the falling edge, with the guards set small but non-zero. It toggles `clk_stable` inside the wait, during the refreshes and after completion, and it applies resets both in the middle of the sequence and after completion.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PRE,
        ST_PGAP,
        ST_REF,
        ST_RGAP,
        ST_MRS,
        ST_MGAP,
        ST_DONE
    } init_state_e;

    typedef struct packed {
        sdr_cmd_e cmd;
        logic     sel_all;
        logic     sel_mode;
        logic     done;
    } pin_req_t;

    function automatic int at_least(int v, int lo);
        return (v < lo) ? lo : v;
    endfunction

    function automatic int max_of4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic pin_req_t state_to_req(init_state_e s);
        pin_req_t r;
        r = '{cmd: CMD_NOP, sel_all: 1'b0, sel_mode: 1'b0, done: 1'b0};
        case (s)
            ST_PRE:  begin r.cmd = CMD_PRE; r.sel_all = 1'b1; end
            ST_REF:  r.cmd = CMD_REF;
            ST_MRS:  begin r.cmd = CMD_MRS; r.sel_mode = 1'b1; end
            ST_DONE: r.done = 1'b1;
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int WAIT_CYC = 14300,
    parameter int T_RP     = 3,
    parameter int T_RFC    = 9,
    parameter int T_MRD    = 2,
    parameter int NUM_REF  = 2,
    parameter int CW       = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_stable,
    input  logic          expired,
    output logic          load,
    output logic [CW-1:0] load_val,
    output init_state_e   state
);
    localparam int NREF = at_least(NUM_REF, 2);
    localparam int RW   = $clog2(NREF + 1);
    localparam logic [CW-1:0] L_WAIT = CW'(at_least(WAIT_CYC, 1) - 1);
    localparam logic [CW-1:0] L_RP   = CW'(at_least(T_RP, 1) - 1);
    localparam logic [CW-1:0] L_RFC  = CW'(at_least(T_RFC, 1) - 1);
    localparam logic [CW-1:0] L_MRD  = CW'(at_least(T_MRD, 1) - 1);
    localparam logic [RW-1:0] LAST_REF = RW'(NREF);

    init_state_e   nxt;
    logic [RW-1:0] ref_cnt;

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        case (state)
            ST_IDLE: if (clk_stable) begin
                nxt = ST_WAIT; load = 1'b1; load_val = L_WAIT;
            end
            ST_WAIT: begin
                if (!clk_stable)  nxt = ST_IDLE;
                else if (expired) nxt = ST_PRE;
            end
            ST_PRE:  begin nxt = ST_PGAP; load = 1'b1; load_val = L_RP;  end
            ST_PGAP: if (expired) nxt = ST_REF;
            ST_REF:  begin nxt = ST_RGAP; load = 1'b1; load_val = L_RFC; end
            ST_RGAP: if (expired) nxt = (ref_cnt == LAST_REF) ? ST_MRS : ST_REF;
            ST_MRS:  begin nxt = ST_MGAP; load = 1'b1; load_val = L_MRD; end
            ST_MGAP: if (expired) nxt = ST_DONE;
            default: nxt = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ref_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_PRE)
                ref_cnt <= '0;
            else if (state == ST_REF)
                ref_cnt <= ref_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
    import sdram_init_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter int              BA_W     = 2,
    parameter int              DQM_W    = 2,
    parameter logic [ADDR_W-1:0] MODE_VAL = 12'h030
) (
    input  init_state_e       state,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              sd_cke,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              init_done
);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

    pin_req_t req;

    always_comb begin
        req = state_to_req(state);
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = req.cmd;
        if (req.sel_mode)     sd_addr = MODE_VAL;
        else if (req.sel_all) sd_addr = ALL_BANKS;
        else                  sd_addr = '0;
        sd_ba     = '0;
        sd_cke    = 1'b1;
        sd_dqm    = '1;
        init_done = req.done;
    end
endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
    import sdram_init_pkg::*;
#(
    parameter int              WAIT_CYC = 14300,
    parameter int              T_RP     = 3,
    parameter int              T_RFC    = 9,
    parameter int              T_MRD    = 2,
    parameter int              NUM_REF  = 2,
    parameter int              ADDR_W   = 12,
    parameter int              BA_W     = 2,
    parameter int              DQM_W    = 2,
    parameter logic [ADDR_W-1:0] MODE_VAL = 12'h030
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_stable,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              sd_cke,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              init_done
);
    localparam int MAXC = max_of4(WAIT_CYC, T_RP, T_RFC, T_MRD);
    localparam int CW   = $clog2(MAXC + 1);

    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_exp;
    init_state_e   state;

    sdram_init_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
    );

    sdram_init_fsm #(
        .WAIT_CYC(WAIT_CYC), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
        .NUM_REF(NUM_REF), .CW(CW)
    ) u_fsm (
        .clk(clk), .rst(rst), .clk_stable(clk_stable), .expired(t_exp),
        .load(t_load), .load_val(t_val), .state(state)
    );

    sdram_init_pins #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .MODE_VAL(MODE_VAL)
    ) u_pins (
        .state(state), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
        .sd_ba(sd_ba), .sd_cke(sd_cke), .sd_dqm(sd_dqm), .init_done(init_done)
    );
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2,
    parameter int DQM_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [BA_W-1:0]   sd_ba,
    input logic              sd_cke,
    input logic [DQM_W-1:0]  sd_dqm,
    input logic              init_done
);
    logic [3:0] cmd;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (cmd == 4'b0111 && !init_done));

    p_cke_dqm_high_r2: assert property (@(posedge clk) disable iff (rst)
        sd_cke && (&sd_dqm));

    p_pre_after_nop_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0010) |-> ($past(cmd) == 4'b0111));

    p_pre_all_banks_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0010) |-> (sd_addr[10] && sd_ba == '0));

    p_ref_after_nop_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0001) |-> ($past(cmd) == 4'b0111));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    p_done_nop_r9: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cmd == 4'b0111));
endmodule

bind sdram_powerup_seq sdram_init_chk #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W)
) u_chk (
    .clk(clk), .rst(rst), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
    .sd_ba(sd_ba), .sd_cke(sd_cke), .sd_dqm(sd_dqm), .init_done(init_done)
);

// File: tb/tb_sdram_powerup_seq.sv
module tb_sdram_powerup_seq;
    localparam int W     = 20;
    localparam int TRP   = 2;
    localparam int TRFC  = 4;
    localparam int TMRD  = 2;
    localparam int NREF  = 3;
    localparam logic [11:0] MODE = 12'h023;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_stable = 1'b0;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, init_done;
    logic [11:0] sd_addr;
    logic [1:0]  sd_ba, sd_dqm;

    always #5 clk = ~clk;

    sdram_powerup_seq #(
        .WAIT_CYC(W), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
        .NUM_REF(NREF), .MODE_VAL(MODE)
    ) dut (
        .clk(clk), .rst(rst), .clk_stable(clk_stable),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
        .sd_cke(sd_cke), .sd_dqm(sd_dqm), .init_done(init_done)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // reference model state
    logic [3:0]  qc[$];
    logic [11:0] qa[$];
    string       qt[$];
    int          run_len = 0;
    bit          started = 0;
    bit          dropped = 0;
    bit          had_run = 0;
    logic [3:0]  e_cmd  = 4'b0111;
    logic [11:0] e_addr = '0;
    bit          e_done = 0;
    string       e_tag  = "R1";

    task automatic push(input logic [3:0] c, input logic [11:0] a, input string t);
        qc.push_back(c); qa.push_back(a); qt.push_back(t);
    endtask

    task automatic build_schedule();
        push(4'b0010, 12'h400, "R5");
        for (int i = 0; i < TRP; i++) push(4'b0111, 12'h000, "R6");
        for (int r = 0; r < NREF; r++) begin
            push(4'b0001, 12'h000, (r == 0) ? "R6" : "R7");
            for (int i = 0; i < TRFC; i++) push(4'b0111, 12'h000, "R7");
        end
        push(4'b0000, MODE, "R8");
        for (int i = 0; i < TMRD; i++) push(4'b0111, 12'h000, "R9");
    endtask

    always @(posedge clk) begin
        if (rst) begin
            qc.delete(); qa.delete(); qt.delete();
            run_len = 0; started = 0; dropped = 0;
            e_cmd = 4'b0111; e_addr = '0; e_done = 0;
            e_tag = had_run ? "R10" : "R1";
        end else begin
            had_run = 1;
            if (!started) begin
                if (clk_stable) run_len++;
                else begin
                    if (run_len > 0) dropped = 1;
                    run_len = 0;
                end
                if (run_len == W + 1) begin
                    started = 1;
                    build_schedule();
                end
            end
            if (started && qc.size() > 0) begin
                e_cmd = qc.pop_front(); e_addr = qa.pop_front(); e_tag = qt.pop_front();
                e_done = 0;
            end else if (started) begin
                e_cmd = 4'b0111; e_addr = '0; e_done = 1; e_tag = "R9";
            end else begin
                e_cmd = 4'b0111; e_addr = '0; e_done = 0;
                e_tag = dropped ? "R4" : "R3";
            end
        end
    end

    always @(negedge clk) begin
        logic [3:0] a_cmd;
        cycles++;
        a_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        checks++;
        if (a_cmd !== e_cmd || sd_addr !== e_addr || sd_ba !== 2'b00) begin
            errors++;
            $display("FAIL %s: cmd=%b addr=%h ba=%b expected cmd=%b addr=%h ba=00",
                     e_tag, a_cmd, sd_addr, sd_ba, e_cmd, e_addr);
        end
        checks++;
        if (sd_cke !== 1'b1 || sd_dqm !== 2'b11) begin
            errors++;
            $display("FAIL R2: cke=%b dqm=%b expected cke=1 dqm=11", sd_cke, sd_dqm);
        end
        checks++;
        if (init_done !== e_done) begin
            errors++;
            $display("FAIL %s: init_done=%b expected %b", e_tag, init_done, e_done);
        end
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected <= 5000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(3);
        rst = 0;                  // R1 reset state observed above
        step(4);                  // clock not yet stable
        clk_stable = 1;
        step(10);
        clk_stable = 0;           // R4 drop inside the wait restarts the count
        step(2);
        clk_stable = 1;
        step(60);                 // full sequence through R9
        clk_stable = 0;           // R4 ignored after completion
        step(3);
        clk_stable = 1;
        step(3);
        rst = 1;                  // R10 reset after completion
        step(2);
        rst = 0;
        step(W + 8);              // into the refresh phase
        clk_stable = 0;           // R4 ignored once precharge issued
        step(3);
        clk_stable = 1;
        step(4);
        rst = 1;                  // R10 reset mid sequence
        step(2);
        rst = 0;
        step(70);
        checks++;
        if (init_done !== 1'b1) begin
            errors++;
            $display("FAIL R10: init_done=%b expected 1 after restart", init_done);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule